// File: doc/BRIEF.md
# Variable-Length Instruction Fetcher with Immediate Extraction

This block fetches one instruction per request for a 16-bit accumulator-style processor. The program memory is one byte wide and answers a read one clock after it is asked. The first byte of every instruction is the opcode. The block classifies that opcode, reads zero, one or two operand bytes after it, and builds a 16-bit immediate. It then presents the opcode, the immediate, the length in bytes and the opcode's address, together with a one-cycle valid pulse. An execution stage drives `fetch_req` whenever it wants the next instruction and uses `branch_load` to redirect the program counter.

The operand of an instruction comes from one of three places. It can be the low nibble of the opcode, which is zero-extended for the quick add/subtract groups and sign-extended for the quick move/compare groups. It can be one following byte, zero- or sign-extended as the opcode dictates. Or it can be a following little-endian pair of bytes. An undefined opcode parks the block in a halt state. A read from above the program-counter ceiling parks it in a fault state. Only a branch load leaves either of them.

The controller has six states:
- ST_IDLE: waits for a request.
- ST_OPCODE: the opcode byte arrives.
- ST_LOW: the first operand byte arrives.
- ST_HIGH: the second operand byte arrives.
- ST_HALT: an undefined opcode was seen.
- ST_FAULT: the ceiling was crossed.

Its transitions are:
- IDLE→OPCODE on an accepted request.
- IDLE→FAULT on a request while the counter is above the ceiling.
- OPCODE→IDLE when the instruction has no operand bytes.
- OPCODE→LOW when operand bytes follow.
- OPCODE→HALT on an undefined opcode.
- OPCODE→FAULT when the first operand byte would be above the ceiling.
- LOW→IDLE for a one-byte operand.
- LOW→HIGH for a two-byte operand.
- LOW→FAULT when the second operand byte would be above the ceiling.
- HIGH→IDLE after the second operand byte.
- any state→IDLE on `branch_load`.

Top module: `ifx_fetch`

## Requirements
- R1: After reset the block is in ST_IDLE, with `fetch_ready`=1, `cur_pc`=0 and `mem_rd`, `instr_valid`, `illegal_op` and `pc_fault` all 0.
- R2: A request accepted in ST_IDLE reads `cur_pc` in the same cycle. Each further byte of the instruction is read in the following consecutive cycle at the next address. Read data is taken one cycle after the read.
- R3: Every byte read advances `cur_pc` by exactly one. While `instr_valid` is high, `cur_pc` equals `instr_addr` + `instr_len`, and `instr_addr` is the opcode's address.
- R4: `instr_len` follows the opcode, and `instr_imm` is 0 when there is no operand.
  - Length 3: 0x02–0x05, 0x2A, 0x49–0x4E, 0x5A, 0x5B, 0x5C, 0x5E and 0x6C, plus the even opcodes in 0x10–0x28, 0x60–0x6A and 0xF4–0xFC.
  - Length 2: the odd opcodes in 0x11–0x29, 0x61–0x6D and 0xF5–0xFD, plus 0x2B, 0x2E, 0x2F, 0x52–0x54, 0x5D and 0x5F.
  - Length 1: every other defined opcode.
- R5: A two-byte operand is little-endian: `instr_imm` = {byte at opcode+2, byte at opcode+1}.
- R6: Opcodes 0xA0–0xEF are one byte long, and their operand is the low 4 bits of the opcode. For 0xA0–0xBF the nibble is zero-extended to 16 bits. For 0xC0–0xEF it is sign-extended from bit 3.
- R7: A one-byte operand is sign-extended for 0x17, 0x19, 0x1B, 0x1D, 0x1F, 0x21, 0xF9, 0xFB and 0xFD. It is zero-extended for every other length-2 opcode.
- R8: `instr_valid` is high for exactly one cycle, the cycle after the last byte of the instruction arrives. That is len+1 cycles after the request cycle.
- R9: The undefined opcodes are 0x50, 0x51, 0x7A–0x9F, 0xF0–0xF3, 0xFE and 0xFF. Such an opcode produces no valid pulse and moves the block to ST_HALT. There `illegal_op`=1, no reads are made and requests are ignored.
- R10: No byte is read from an address above PC_LIMIT (default 0xA000); the address 0xA000 itself can be read. An attempt to read above it leaves `cur_pc` unchanged, moves the block to ST_FAULT with `pc_fault`=1, and produces no valid pulse.
- R11: `branch_load` wins in every state. It loads `cur_pc` from `branch_target` by the next cycle and returns the block to ST_IDLE. It clears halt and fault, suppresses any read in its own cycle, and discards a partly fetched instruction.
- R12: `fetch_req` is ignored outside ST_IDLE, where `fetch_ready` is 0. Holding it high during a fetch causes no extra read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Request the next instruction (sampled in ST_IDLE) |
| branch_load | input | 1 | Replace the program counter and abandon any fetch |
| branch_target | input | ADDR_W | New program counter value |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | ADDR_W | Program memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| instr_valid | output | 1 | One-cycle pulse: instruction fields are complete |
| instr_opcode | output | 8 | Opcode byte |
| instr_imm | output | 16 | Extended immediate |
| instr_len | output | 2 | Instruction length in bytes (1 to 3) |
| instr_addr | output | ADDR_W | Address of the opcode byte |
| cur_pc | output | ADDR_W | Current program counter |
| fetch_ready | output | 1 | Block is in ST_IDLE |
| illegal_op | output | 1 | Block is halted on an undefined opcode |
| pc_fault | output | 1 | Block stopped on a read above PC_LIMIT |

## Verification
The assertions check several properties on every cycle:
- Consecutive reads within one instruction use consecutive addresses, and each read moves the counter by one.
- No read goes above the ceiling, and the halt and fault states stay silent.
- The valid pulse is never longer than one cycle, and the counter agrees with the reported address and length whenever it is high.
- A branch load always lands the counter on its target.

Some behaviour only the bench scenarios can show:
- Whether each opcode group gets the right length and extension.
- Whether the pulse comes exactly len+1 cycles after the request.
- Whether a fetch abandoned by a branch really produces no instruction.
- Whether a held request is ignored mid-fetch.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    localparam int OP_W  = 8;
    localparam int IMM_W = 16;

    // Where the operand of an instruction comes from
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NIB  = 2'd1,
        SRC_BYTE = 2'd2,
        SRC_WORD = 2'd3
    } imm_src_e;

    typedef struct packed {
        logic     legal;
        imm_src_e src;
        logic     sext;
    } op_class_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_LOW    = 3'd2,
        ST_HIGH   = 3'd3,
        ST_HALT   = 3'd4,
        ST_FAULT  = 3'd5
    } fetch_state_e;

    function automatic logic [1:0] src_len(imm_src_e s);
        case (s)
            SRC_BYTE: return 2'd2;
            SRC_WORD: return 2'd3;
            default:  return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/ifx_decode.sv
module ifx_decode
    import ifx_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_class_t       cls
);

    always_comb begin
        cls.legal = 1'b1;
        cls.src   = SRC_NONE;
        cls.sext  = 1'b0;
        if (op inside {[8'h02:8'h05], 8'h2A, [8'h49:8'h4E],
                       8'h5A, 8'h5B, 8'h5C, 8'h5E, 8'h6C}) begin
            cls.src = SRC_WORD;
        end else if (op inside {[8'h10:8'h29], [8'h60:8'h6B], [8'hF4:8'hFD]}) begin
            // paired groups: even = word operand, odd = byte operand
            cls.src  = op[0] ? SRC_BYTE : SRC_WORD;
            cls.sext = op[0] && (op inside {[8'h16:8'h21], [8'hF8:8'hFD]});
        end else if (op inside {8'h2B, 8'h2E, 8'h2F, [8'h52:8'h54],
                                8'h5D, 8'h5F, 8'h6D}) begin
            cls.src = SRC_BYTE;
        end else if (op inside {[8'hA0:8'hEF]}) begin
            cls.src  = SRC_NIB;
            cls.sext = (op >= 8'hC0);
        end else if (op inside {8'h50, 8'h51, [8'h7A:8'h9F],
                                [8'hF0:8'hF3], 8'hFE, 8'hFF}) begin
            cls.legal = 1'b0;
        end
    end

endmodule

// File: rtl/ifx_imm.sv
module ifx_imm
    import ifx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  imm_src_e         src,
    input  logic             sext,
    input  logic [NIB_W-1:0] nib,
    input  logic [7:0]       lo,
    input  logic [7:0]       hi,
    output logic [IMM_W-1:0] imm
);

    localparam int NIB_PAD  = IMM_W - NIB_W;
    localparam int BYTE_PAD = IMM_W - 8;

    always_comb begin
        unique case (src)
            SRC_NIB:  imm = {{NIB_PAD{sext & nib[NIB_W-1]}}, nib};
            SRC_BYTE: imm = {{BYTE_PAD{sext & lo[7]}}, lo};
            SRC_WORD: imm = {hi, lo};
            default:  imm = '0;
        endcase
    end

endmodule

// File: rtl/ifx_pc.sv
module ifx_pc #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (load) pc <= target;
        else if (step) pc <= pc + 1'b1;
    end

endmodule

// File: rtl/ifx_fetch.sv
module ifx_fetch
    import ifx_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PC_LIMIT = 'hA000,
    parameter int                NIB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              branch_load,
    input  logic [ADDR_W-1:0] branch_target,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              instr_valid,
    output logic [OP_W-1:0]   instr_opcode,
    output logic [IMM_W-1:0]  instr_imm,
    output logic [1:0]        instr_len,
    output logic [ADDR_W-1:0] instr_addr,
    output logic [ADDR_W-1:0] cur_pc,
    output logic              fetch_ready,
    output logic              illegal_op,
    output logic              pc_fault
);

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] start_q;
    logic [OP_W-1:0]   op_q;
    logic [7:0]        lo_q;
    logic [OP_W-1:0]   dec_op;
    logic [7:0]        lo_sel;
    op_class_t         cls;
    logic [IMM_W-1:0]  imm_w;
    logic              addr_ok;
    logic              rd_en;
    logic              finish;

    // one decoder: live byte while it arrives, held copy afterwards
    assign dec_op  = (state_q == ST_OPCODE) ? mem_rdata : op_q;
    assign lo_sel  = (state_q == ST_LOW) ? mem_rdata : lo_q;
    assign addr_ok = (pc_q <= PC_LIMIT);

    ifx_decode u_decode (
        .op  (dec_op),
        .cls (cls)
    );

    ifx_imm #(.NIB_W(NIB_W)) u_imm (
        .src  (cls.src),
        .sext (cls.sext),
        .nib  (dec_op[NIB_W-1:0]),
        .lo   (lo_sel),
        .hi   (mem_rdata),
        .imm  (imm_w)
    );

    ifx_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (branch_load),
        .target (branch_target),
        .step   (rd_en),
        .pc     (pc_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and read strobe
    always_comb begin
        state_d = state_q;
        rd_en   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch_req) begin
                    if (addr_ok) begin
                        rd_en   = 1'b1;
                        state_d = ST_OPCODE;
                    end else begin
                        state_d = ST_FAULT;
                    end
                end
            end
            ST_OPCODE: begin
                if (!cls.legal) begin
                    state_d = ST_HALT;
                end else if (cls.src == SRC_NONE || cls.src == SRC_NIB) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else if (addr_ok) begin
                    rd_en   = 1'b1;
                    state_d = ST_LOW;
                end else begin
                    state_d = ST_FAULT;
                end
            end
            ST_LOW: begin
                if (cls.src == SRC_BYTE) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else if (addr_ok) begin
                    rd_en   = 1'b1;
                    state_d = ST_HIGH;
                end else begin
                    state_d = ST_FAULT;
                end
            end
            ST_HIGH: begin
                finish  = 1'b1;
                state_d = ST_IDLE;
            end
            ST_HALT, ST_FAULT: state_d = state_q;
            default:           state_d = ST_IDLE;
        endcase
        if (branch_load) begin
            state_d = ST_IDLE;
            rd_en   = 1'b0;
            finish  = 1'b0;
        end
    end

    // capture registers and result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q         <= '0;
            lo_q         <= '0;
            start_q      <= '0;
            instr_valid  <= 1'b0;
            instr_opcode <= '0;
            instr_imm    <= '0;
            instr_len    <= 2'd0;
            instr_addr   <= '0;
        end else begin
            instr_valid <= finish;
            if (state_q == ST_IDLE && rd_en)         start_q <= pc_q;
            if (state_q == ST_OPCODE && !branch_load) op_q   <= mem_rdata;
            if (state_q == ST_LOW && !branch_load)    lo_q   <= mem_rdata;
            if (finish) begin
                instr_opcode <= dec_op;
                instr_imm    <= imm_w;
                instr_len    <= src_len(cls.src);
                instr_addr   <= start_q;
            end
        end
    end

    assign mem_rd      = rd_en;
    assign mem_addr    = pc_q;
    assign cur_pc      = pc_q;
    assign fetch_ready = (state_q == ST_IDLE);
    assign illegal_op  = (state_q == ST_HALT);
    assign pc_fault    = (state_q == ST_FAULT);

endmodule

// File: rtl/ifx_fetch_chk.sv
module ifx_fetch_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PC_LIMIT = 'hA000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              branch_load,
    input logic [ADDR_W-1:0] branch_target,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              instr_valid,
    input logic [7:0]        instr_opcode,
    input logic [15:0]       instr_imm,
    input logic [1:0]        instr_len,
    input logic [ADDR_W-1:0] instr_addr,
    input logic [ADDR_W-1:0] cur_pc,
    input logic              fetch_ready,
    input logic              illegal_op,
    input logic              pc_fault
);

    AST_RD_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !fetch_ready) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (cur_pc == $past(cur_pc) + 1'b1)); // R3

    AST_VALID_PC: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (cur_pc == instr_addr + ADDR_W'(instr_len))); // R3

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (instr_len != 2'd0)); // R4

    AST_NIB_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr_opcode inside {[8'hC0:8'hEF]}))
        |-> (instr_imm == {{12{instr_opcode[3]}}, instr_opcode[3:0]})); // R6

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid); // R8

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!mem_rd && !instr_valid)); // R9

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({illegal_op, pc_fault, fetch_ready})); // R9

    AST_NO_READ_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr <= PC_LIMIT)); // R10

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pc_fault |-> !mem_rd); // R10

    AST_BRANCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        branch_load |=> ((cur_pc == $past(branch_target)) && fetch_ready)); // R11

    AST_BRANCH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        branch_load |-> !mem_rd); // R11

endmodule

bind ifx_fetch ifx_fetch_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .branch_load   (branch_load),
    .branch_target (branch_target),
    .mem_rd        (mem_rd),
    .mem_addr      (mem_addr),
    .instr_valid   (instr_valid),
    .instr_opcode  (instr_opcode),
    .instr_imm     (instr_imm),
    .instr_len     (instr_len),
    .instr_addr    (instr_addr),
    .cur_pc        (cur_pc),
    .fetch_ready   (fetch_ready),
    .illegal_op    (illegal_op),
    .pc_fault      (pc_fault)
);

// File: tb/ifx_fetch_tb_top.sv
`timescale 1ns/1ps
module ifx_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic        branch_load = 1'b0;
    logic [15:0] branch_target = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        instr_valid;
    logic [7:0]  instr_opcode;
    logic [15:0] instr_imm;
    logic [1:0]  instr_len;
    logic [15:0] instr_addr;
    logic [15:0] cur_pc;
    logic        fetch_ready;
    logic        illegal_op;
    logic        pc_fault;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0]  op;
        logic [15:0] imm;
        int          len;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [7:0] mem_model [logic [15:0]];

    always #10 clk = ~clk;

    ifx_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
        .branch_load(branch_load), .branch_target(branch_target),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .instr_valid(instr_valid), .instr_opcode(instr_opcode),
        .instr_imm(instr_imm), .instr_len(instr_len),
        .instr_addr(instr_addr), .cur_pc(cur_pc),
        .fetch_ready(fetch_ready), .illegal_op(illegal_op),
        .pc_fault(pc_fault)
    );

    // program memory: one cycle read latency
    always @(posedge clk)
        if (mem_rd) mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // expected behaviour from the requirement text
    function automatic void model(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                                  output logic [15:0] imm, output int len,
                                  output bit bad, output string tag);
        bit w, b, s;
        bad = op inside {8'h50, 8'h51, [8'h7A:8'h9F], [8'hF0:8'hF3], 8'hFE, 8'hFF};
        w = (op inside {[8'h02:8'h05], 8'h2A, [8'h49:8'h4E], 8'h5A, 8'h5B, 8'h5C, 8'h5E, 8'h6C})
            || (!op[0] && (op inside {[8'h10:8'h28], [8'h60:8'h6A], [8'hF4:8'hFC]}));
        b = (op[0] && (op inside {[8'h11:8'h29], [8'h61:8'h6D], [8'hF5:8'hFD]}))
            || (op inside {8'h2B, 8'h2E, 8'h2F, [8'h52:8'h54], 8'h5D, 8'h5F});
        s = op inside {8'h17, 8'h19, 8'h1B, 8'h1D, 8'h1F, 8'h21, 8'hF9, 8'hFB, 8'hFD};
        if (w) begin
            len = 3; imm = {b2, b1}; tag = "R5 word operand";
        end else if (b) begin
            len = 2; imm = (s && b1[7]) ? {8'hFF, b1} : {8'h00, b1}; tag = "R7 byte operand";
        end else if (op inside {[8'hA0:8'hEF]}) begin
            len = 1; imm = (op >= 8'hC0 && op[3]) ? {12'hFFF, op[3:0]} : {12'h000, op[3:0]};
            tag = "R6 nibble operand";
        end else begin
            len = 1; imm = 16'h0000; tag = "R4 no operand";
        end
    endfunction

    // driver: place an instruction, push its expectation if one is due
    task automatic put(input logic [15:0] a, input logic [7:0] op, input logic [7:0] b1,
                       input logic [7:0] b2, input bit expect_it, output int len);
        exp_t e;
        bit bad;
        mem_model[a] = op;
        mem_model[a + 16'd1] = b1;
        mem_model[a + 16'd2] = b2;
        model(op, b1, b2, e.imm, e.len, bad, e.tag);
        e.op = op;
        e.addr = a;
        len = e.len;
        if (expect_it && !bad) sb_q.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic branch_to(input logic [15:0] a);
        branch_load = 1'b1; branch_target = a;
        tick();
        branch_load = 1'b0;
    endtask

    task automatic issue();
        fetch_req = 1'b1;
        tick();
        fetch_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (fetch_ready) break;
        end
        tick();
    endtask

    // monitor: scoreboard comparison on every valid pulse
    always @(negedge clk) begin
        if (rst_n && instr_valid) begin
            if (sb_q.size() == 0) begin
                chk("R8 valid pulse with nothing expected", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4 opcode", {24'd0, instr_opcode}, {24'd0, e.op});
                chk("R4 length", {30'd0, instr_len}, e.len);
                chk("R3 opcode address", {16'd0, instr_addr}, {16'd0, e.addr});
                chk(e.tag, {16'd0, instr_imm}, {16'd0, e.imm});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        summary();
    end

    initial begin
        int ln;
        logic [15:0] wp;
        logic [7:0] prog [23][3];
        logic [7:0] bad_ops [6];

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", fetch_ready, 1);
        chk("R1 no read after reset", mem_rd, 0);
        chk("R1 no valid after reset", instr_valid, 0);
        chk("R1 pc after reset", cur_pc, 0);
        chk("R1 no halt after reset", illegal_op, 0);
        chk("R1 no fault after reset", pc_fault, 0);
        tick();

        // stream of mixed instructions at 0x0100
        prog = '{'{8'h01,8'h00,8'h00}, '{8'h02,8'h34,8'h12}, '{8'h11,8'h80,8'h00},
                 '{8'h17,8'h80,8'h00}, '{8'h17,8'h7F,8'h00}, '{8'hA5,8'h00,8'h00},
                 '{8'hAF,8'h00,8'h00}, '{8'hB8,8'h00,8'h00}, '{8'hC8,8'h00,8'h00},
                 '{8'hC7,8'h00,8'h00}, '{8'hEF,8'h00,8'h00}, '{8'hD0,8'h00,8'h00},
                 '{8'hF9,8'hFE,8'h00}, '{8'hF5,8'hFE,8'h00}, '{8'hFD,8'h80,8'h00},
                 '{8'h2B,8'h90,8'h00}, '{8'h63,8'h90,8'h00}, '{8'h6C,8'hCD,8'hAB},
                 '{8'h5D,8'h05,8'h00}, '{8'h4F,8'h00,8'h00}, '{8'h30,8'h00,8'h00},
                 '{8'h70,8'h00,8'h00}, '{8'h2C,8'h00,8'h00}};
        wp = 16'h0100;
        foreach (prog[i]) begin
            put(wp, prog[i][0], prog[i][1], prog[i][2], 1'b1, ln);
            wp = wp + 16'(ln);
        end
        branch_to(16'h0100);
        foreach (prog[i]) issue();
        chk("R4 stream fully consumed", sb_q.size(), 0);
        chk("R3 pc after stream", cur_pc, wp);

        // R2 R8 R12: cycle timing of a 3-byte fetch with request held high
        put(16'h0200, 8'hF8, 8'h34, 8'h12, 1'b1, ln);
        branch_to(16'h0200);
        fetch_req = 1'b1;
        @(negedge clk);
        chk("R2 read in request cycle", mem_rd, 1);
        chk("R2 opcode address", mem_addr, 16'h0200);
        tick();
        @(negedge clk);
        chk("R2 low byte read", mem_rd, 1);
        chk("R2 low byte address", mem_addr, 16'h0201);
        tick();
        @(negedge clk);
        chk("R2 high byte read", mem_rd, 1);
        chk("R2 high byte address", mem_addr, 16'h0202);
        tick();
        @(negedge clk);
        chk("R12 held request makes no read", mem_rd, 0);
        chk("R8 no valid before last byte done", instr_valid, 0);
        tick();
        fetch_req = 1'b0;
        @(negedge clk);
        chk("R8 valid at len+1 cycles", instr_valid, 1);
        chk("R3 pc after 3-byte fetch", cur_pc, 16'h0203);
        tick();
        @(negedge clk);
        chk("R8 valid lasts one cycle", instr_valid, 0);
        tick();

        // R11: branch discards a partial fetch and wins over a request
        put(16'h0300, 8'h02, 8'h00, 8'h40, 1'b0, ln);
        put(16'h0400, 8'hC9, 8'h00, 8'h00, 1'b1, ln);
        branch_to(16'h0300);
        fetch_req = 1'b1;
        tick();
        fetch_req = 1'b0;
        tick();
        branch_load = 1'b1; branch_target = 16'h0400;
        @(negedge clk);
        chk("R11 branch suppresses read mid-fetch", mem_rd, 0);
        tick();
        branch_load = 1'b0;
        @(negedge clk);
        chk("R11 pc loaded", cur_pc, 16'h0400);
        chk("R11 back to idle", fetch_ready, 1);
        tick();
        tick();
        chk("R11 discarded instruction gives no valid", sb_q.size(), 1);
        branch_load = 1'b1; branch_target = 16'h0400; fetch_req = 1'b1;
        @(negedge clk);
        chk("R11 branch wins over request", mem_rd, 0);
        tick();
        branch_load = 1'b0; fetch_req = 1'b0;
        issue();
        chk("R11 fetch after branch delivered", sb_q.size(), 0);

        // R9: undefined opcodes halt
        bad_ops = '{8'h50, 8'h7A, 8'h9F, 8'hF0, 8'hFE, 8'hFF};
        foreach (bad_ops[i]) begin
            logic [15:0] a;
            a = 16'h0500 + 16'(i * 16);
            put(a, bad_ops[i], 8'h00, 8'h00, 1'b1, ln);
            branch_to(a);
            chk("R11 branch clears halt", illegal_op, 0);
            issue();
            chk("R9 halted on undefined opcode", illegal_op, 1);
            chk("R9 pc after undefined opcode", cur_pc, a + 16'd1);
            fetch_req = 1'b1;
            @(negedge clk);
            chk("R9 request ignored while halted", mem_rd, 0);
            tick();
            fetch_req = 1'b0;
        end
        chk("R9 no valid from undefined opcodes", sb_q.size(), 0);

        // R10: program counter ceiling
        put(16'h9FFF, 8'h13, 8'h44, 8'h00, 1'b1, ln);
        branch_to(16'h9FFF);
        issue();
        chk("R10 byte at ceiling readable", cur_pc, 16'hA001);
        fetch_req = 1'b1;
        @(negedge clk);
        chk("R10 no read above ceiling", mem_rd, 0);
        tick();
        fetch_req = 1'b0;
        @(negedge clk);
        chk("R10 fault raised", pc_fault, 1);
        chk("R10 pc unchanged on fault", cur_pc, 16'hA001);
        tick();
        put(16'h9FFF, 8'h02, 8'h11, 8'h22, 1'b0, ln);
        branch_to(16'h9FFF);
        chk("R11 branch clears fault", pc_fault, 0);
        issue();
        chk("R10 fault mid-instruction", pc_fault, 1);
        chk("R10 pc stops at first blocked byte", cur_pc, 16'hA001);
        put(16'hA000, 8'h01, 8'h00, 8'h00, 1'b1, ln);
        branch_to(16'hA000);
        issue();
        chk("R10 opcode at ceiling fetched", pc_fault, 0);
        chk("R10 all expected delivered", sb_q.size(), 0);

        tick();
        summary();
    end

endmodule